// File: doc/BRIEF.md
# Programmable Input Deglitch Filter

This block cleans up a bank of 24 digital inputs. Each input is first brought into the clock domain through a two-flop synchroniser. It then passes either straight through or through a deglitch stage. In the deglitch stage the output takes a new value only once the synchronised input has held that value for a programmed number of 200 ns ticks. All channels share one hold interval. Each channel has its own enable bit, which chooses filtering or bypass.

Software writes byte-wide configuration through a small write port. The interval goes into a shadow register and takes effect only when a reload command is written. The same command register also offers a filter-state reset, which loads every filtered output with its present synchronised input. A divider built from the system clock frequency produces the 200 ns timebase.

Top module: `deglitch_bank`

## Requirements
- R1: While reset is held, and directly after it is released, every filtered output reads 0 and every channel enable is clear. With all enables clear, each output follows its own input.
- R2: A channel whose enable is clear shows its input on its output three clock edges after the input changes: two synchroniser stages and one output register.
- R3: On an enabled channel, the output takes a new value only after the synchronised input has differed from it for the active interval, counted in timebase ticks. A pulse held for fewer ticks than the interval leaves the output unchanged.
- R4: On an enabled channel, the tick count restarts whenever the synchronised input returns to the output value. Two short pulses therefore never add up to one long pulse.
- R5: The 20-bit interval is written little-endian. Address 0 holds bits 7:0, address 1 holds bits 15:8, and address 2 holds bits 19:16 in its data bits 3:0. Data bits 7:4 at address 2 are discarded.
- R6: An interval write changes only the shadow copy. The active interval takes the shadow value when address 8 is written with data bit 0 set.
- R7: Writing address 8 with data bit 1 set makes every filtered output equal to its synchronised input on the next clock edge and clears all tick counts.
- R8: The timebase emits a single-cycle tick once every CLK_HZ*200/10^9 clocks, which is every 10 clocks at 50 MHz.
- R9: Channel enables are written at addresses 4, 5 and 6. Data bit i at address 4+k enables channel 8k+i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 24 | Raw asynchronous digital inputs |
| cfg_we | input | 1 | Configuration write strobe, one cycle per byte |
| cfg_addr | input | 4 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| filt_out | output | 24 | Filtered (or bypassed) inputs |

## Verification
The assertions assume that a write strobe lasts a single cycle and that reset is held for at least as many cycles as the synchroniser has stages. The bench always drives one-cycle strobes and holds reset for five cycles. The timing properties assume that the enable bit of a channel is taken from the cycle before its output changes, which holds because enables are registered. The stimulus changes inputs only at least 1 ns after a falling edge, so the edge on which an input is sampled is unambiguous. Pulse lengths are chosen well clear of the tick-phase uncertainty, so each check has a single expected value.

// File: rtl/deglitch_pkg.sv
// Shared constants for the deglitch bank: configuration address map and
// command bit positions. Assumes interval and enable fields each fit in
// four byte lanes.
package deglitch_pkg;
    localparam int ADDR_W         = 4;
    localparam int IVL_BASE       = 0;
    localparam int EN_BASE        = 4;
    localparam int CMD_ADDR       = 8;
    localparam int CMD_RELOAD_BIT = 0;
    localparam int CMD_CLEAR_BIT  = 1;
endpackage

// File: rtl/deglitch_tick.sv
// Timebase divider: emits a one-cycle tick every TICK_NS of system time.
// Assumes CLK_HZ*TICK_NS is a multiple of 1e9 (otherwise it rounds down).
module deglitch_tick #(
    parameter int CLK_HZ  = 50_000_000,
    parameter int TICK_NS = 200
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam longint DIV_L = (longint'(CLK_HZ) * longint'(TICK_NS)) / 64'd1_000_000_000;
    localparam int     DIV   = (DIV_L < 1) ? 1 : int'(DIV_L);
    localparam int     CW    = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV == 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            logic [CW-1:0] cnt;

            // Count clocks and wrap once per timebase period.
            always_ff @(posedge clk) begin
                if (!rst_n)                     cnt <= '0;
                else if (cnt == CW'(DIV - 1))   cnt <= '0;
                else                            cnt <= cnt + 1'b1;
            end

            assign tick = rst_n && (cnt == CW'(DIV - 1));

            // R8: the tick is a single-cycle pulse
            assert_tick_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/deglitch_cfg.sv
// Configuration registers: shadow and active interval, channel enables and
// command decode. Assumes single-cycle write strobes.
module deglitch_cfg
    import deglitch_pkg::*;
#(
    parameter int IVL_W    = 20,
    parameter int CHANNELS = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [IVL_W-1:0]  ivl_active,
    output logic [CHANNELS-1:0] en_mask,
    output logic              flt_clr
);
    logic [IVL_W-1:0] ivl_shadow;
    logic             cmd_hit;
    logic             reload;

    assign cmd_hit = we && (addr == ADDR_W'(CMD_ADDR));
    assign reload  = cmd_hit && wdata[CMD_RELOAD_BIT];
    assign flt_clr = cmd_hit && wdata[CMD_CLEAR_BIT];

    // Shadow interval: bit b lives in lane b/8; bits beyond IVL_W are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ivl_shadow <= '0;
        end else begin
            for (int b = 0; b < IVL_W; b++) begin
                if (we && addr == ADDR_W'(IVL_BASE + b / 8))
                    ivl_shadow[b] <= wdata[b % 8];
            end
        end
    end

    // Active interval follows the shadow only on a reload command.
    always_ff @(posedge clk) begin
        if (!rst_n)      ivl_active <= '0;
        else if (reload) ivl_active <= ivl_shadow;
    end

    // Per-channel enables, byte lane per eight channels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_mask <= '0;
        end else begin
            for (int c = 0; c < CHANNELS; c++) begin
                if (we && addr == ADDR_W'(EN_BASE + c / 8))
                    en_mask[c] <= wdata[c % 8];
            end
        end
    end

    // R6: the active interval holds unless a reload is commanded
    assert_active_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !reload |=> $stable(ivl_active));
endmodule

// File: rtl/deglitch_chan.sv
// One channel: synchroniser, stability counter and filtered output.
// Assumes tick is a one-cycle pulse and ivl is shared by all channels.
module deglitch_chan #(
    parameter int IVL_W       = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             en,
    input  logic             flt_clr,
    input  logic [IVL_W-1:0] ivl,
    input  logic             pin,
    output logic             out
);
    logic [SYNC_STAGES-1:0] sq;
    logic                   sync;
    logic [IVL_W-1:0]       cnt;
    logic [IVL_W:0]         cnt_inc;
    logic                   reached;

    assign sync    = sq[SYNC_STAGES-1];
    assign cnt_inc = {1'b0, cnt} + 1'b1;
    assign reached = cnt_inc >= {1'b0, ivl};

    // Bring the raw pin into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sq <= '0;
        else        sq <= {sq[SYNC_STAGES-2:0], pin};
    end

    // Filter: restart on agreement, count ticks on disagreement, commit at limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out <= 1'b0;
            cnt <= '0;
        end else if (flt_clr || !en) begin
            out <= sync;
            cnt <= '0;
        end else if (sync == out) begin
            cnt <= '0;
        end else if (tick) begin
            if (reached) begin
                out <= sync;
                cnt <= '0;
            end else begin
                cnt <= cnt_inc[IVL_W-1:0];
            end
        end
    end

    // R3: an enabled channel changes only on a tick edge
    assert_hold_between_ticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick && !flt_clr) |=> $stable(out));

    // R4: an enabled channel can only move to the value its input held
    assert_moves_to_input_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !flt_clr) |=> (out == $past(out) || out == $past(sync)));

    // R7: a filter-state reset loads the synchronised input
    assert_clear_loads_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flt_clr |=> out == $past(sync));
endmodule

// File: rtl/deglitch_bank.sv
// Top: bank of deglitch channels sharing one timebase and one interval.
// Assumes asynchronous pins; the configuration port is byte-wide and
// write-only, with one-cycle strobes.
module deglitch_bank
    import deglitch_pkg::*;
#(
    parameter int CLK_HZ      = 50_000_000,
    parameter int TICK_NS     = 200,
    parameter int CHANNELS    = 24,
    parameter int IVL_W       = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CHANNELS-1:0] pin_in,
    input  logic                cfg_we,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [7:0]          cfg_wdata,
    output logic [CHANNELS-1:0] filt_out
);
    logic                tick;
    logic [IVL_W-1:0]    ivl_active;
    logic [CHANNELS-1:0] en_mask;
    logic                flt_clr;

    deglitch_tick #(.CLK_HZ(CLK_HZ), .TICK_NS(TICK_NS)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    deglitch_cfg #(.IVL_W(IVL_W), .CHANNELS(CHANNELS)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .ivl_active(ivl_active), .en_mask(en_mask), .flt_clr(flt_clr)
    );

    generate
        for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
            deglitch_chan #(.IVL_W(IVL_W), .SYNC_STAGES(SYNC_STAGES)) u_ch (
                .clk(clk), .rst_n(rst_n), .tick(tick), .en(en_mask[c]),
                .flt_clr(flt_clr), .ivl(ivl_active), .pin(pin_in[c]), .out(filt_out[c])
            );
        end
    endgenerate
endmodule

// File: tb/deglitch_bank_tb.sv
module deglitch_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] pins = '0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [23:0] filt_out;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    typedef struct {
        int          at;
        logic [23:0] exp;
        logic [23:0] mask;
        string       tag;
    } item_t;
    item_t sb[$];

    always #10 clk = ~clk;

    deglitch_bank u_dut (
        .clk(clk), .rst_n(rst_n), .pin_in(pins), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .filt_out(filt_out)
    );

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // Monitor: pop due expectations and compare at the falling edge.
    always @(negedge clk) begin
        cyc++;
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            item_t it;
            it = sb.pop_front();
            tests++;
            if ((filt_out & it.mask) !== (it.exp & it.mask)) begin
                fails++;
                $display("FAIL %s actual=%h expected=%h (mask %h)", it.tag,
                         filt_out & it.mask, it.exp & it.mask, it.mask);
            end
        end
        if (cyc == 20000) begin
            tests++;
            fails++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            summary();
        end
    end

    task automatic step(int n);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    // Driver side: push an expectation due d cycles from now, kept sorted.
    task automatic expect_in(int d, logic [23:0] e, logic [23:0] m, string tag);
        item_t it;
        int pos;
        it.at = cyc + d; it.exp = e; it.mask = m; it.tag = tag;
        pos = sb.size();
        for (int i = 0; i < sb.size(); i++) begin
            if (sb[i].at > it.at) begin pos = i; break; end
        end
        sb.insert(pos, it);
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        step(1);
        cfg_we = 1'b0;
    endtask

    initial begin
        step(5);
        rst_n = 1'b1;
        step(1);
        // R1: outputs clear after reset
        expect_in(1, 24'h000000, 24'hFFFFFF, "R1 reset outputs");
        step(2);
        pins = 24'hA5A5A5;
        // R1 R2: all channels bypass after reset
        expect_in(4, 24'hA5A5A5, 24'hFFFFFF, "R1/R2 bypass after reset");
        step(6);

        // R5: interval 3, high nibble of lane 2 discarded; enable ch0 (R9)
        wr(4'd0, 8'h03); wr(4'd1, 8'h00); wr(4'd2, 8'hF0); wr(4'd8, 8'h01);
        wr(4'd4, 8'h01);
        step(2);
        pins = 24'hA5A5A4;
        expect_in(20, 24'h000001, 24'h000001, "R3 held before interval");
        expect_in(35, 24'h000000, 24'h000001, "R3/R5 change after 3 ticks");
        step(40);

        // R3: short pulse ignored
        pins = 24'hA5A5A5;
        expect_in(15, 24'h0, 24'h1, "R3 short pulse mid");
        expect_in(45, 24'h0, 24'h1, "R3 short pulse after");
        step(15);
        pins = 24'hA5A5A4;
        step(40);

        // R4: two short pulses separated by a gap do not accumulate
        pins = 24'hA5A5A5;
        expect_in(45, 24'h0, 24'h1, "R4 counter restart");
        step(15);
        pins = 24'hA5A5A4;
        step(3);
        pins = 24'hA5A5A5;
        step(15);
        pins = 24'hA5A5A4;
        step(40);

        // R2: bypass channel moves while filtered channel waits
        pins = 24'hA5A5A7;
        expect_in(4, 24'h000002, 24'h000003, "R2 bypass beside filtered");
        expect_in(35, 24'h000003, 24'h000003, "R3 filtered catches up");
        step(40);

        // R6: shadow write without reload keeps interval 3
        wr(4'd0, 8'h06);
        step(1);
        pins = 24'hA5A5A6;
        expect_in(35, 24'h0, 24'h1, "R6 old interval still active");
        step(40);
        wr(4'd8, 8'h01);
        step(1);
        pins = 24'hA5A5A7;
        expect_in(48, 24'h0, 24'h1, "R6 new interval not yet");
        expect_in(65, 24'h1, 24'h1, "R6 new interval applied");
        step(70);

        // R7: long interval, then filter-state reset
        wr(4'd1, 8'h10); wr(4'd8, 8'h01);
        step(1);
        pins = 24'hA5A5A6;
        expect_in(100, 24'h1, 24'h1, "R7 long interval holding");
        step(100);
        wr(4'd8, 8'h02);
        expect_in(1, 24'h0, 24'h1, "R7 clear loads input");
        step(3);

        // R9: lane 2 bit 7 enables ch23 only; ch16 still bypassed
        wr(4'd6, 8'h80);
        step(1);
        pins = 24'h24A5A6;
        expect_in(4, 24'h800000, 24'h810000, "R9 ch23 filtered ch16 bypass");
        expect_in(20, 24'h800000, 24'h800000, "R9 ch23 holds");
        step(25);

        while (sb.size() > 0) step(1);
        summary();
    end
endmodule